// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block brings a bank of up to eight SDRAM rows from reset to normal operation. One start pulse with the mode selection at zero runs the whole initialisation script: a long settling wait, a NOP broadcast, a second long wait, a precharge-all broadcast, a configurable number of auto-refresh (CBR) broadcasts, and a mode-register-set broadcast. After the last gap the block enters normal mode and turns on the periodic refresh tick. A start pulse with a mode value from 1 to 4 issues that one command to the rows and then stops. This covers bring-up steps that firmware runs by hand. Mode values 5 to 7 are reserved.

Each broadcast visits the rows in ascending order, one row per clock. The rows are described by cumulative boundary values in 8 MB units. A row gets a chip-select strobe only when its boundary is larger than the boundary of the row below it. Each strobe carries the command code, the row's start address (the lower boundary), and for mode-register-set the address word to put on the bus. That word depends on the CAS latency and on whether the row is in the lower or the upper half of the array. All waits are counted in clock cycles and set by parameters.

Top module: `sdr_init_seq`

## Requirements
- R1: After synchronous reset, row_cs_o, cmd_o, mra_o and row_base_o are zero, and done_o and refresh_tick_o are low.
- R2: A start with mode 0 runs the sequence NOP, precharge-all, N_CBR auto-refreshes, mode-register-set. Row 0 of the first broadcast is strobed T_PWR+1 cycles after the start edge. Each later broadcast begins 8+D cycles after the previous one began, where D is T_PWR after NOP, T_RP after precharge, T_RC after each refresh, and the final gap is T_MRD.
- R3: A broadcast visits rows 0 to 7, one per cycle in ascending order. Row r is strobed (row_cs_o bit r, one-hot) only if its boundary is greater than the boundary of row r-1, and row 0 is compared against 0. cmd_o carries 1=NOP, 2=precharge-all, 3=mode-register-set or 4=auto-refresh with the strobe. Boundaries are packed at row_bound_i[8r+7:8r].
- R4: With each strobe, row_base_o equals the boundary of the previous row, which is 0 for row 0.
- R5: For mode-register-set, mra_o is 0x1D0 for rows 0-3 and 0x1E28 for rows 4-7 when cas_l3_i=1, and 0x150 and 0x1EA8 when cas_l3_i=0. For every other command mra_o is 0.
- R6: A start with mode 1 to 4 broadcasts that single command starting on the next cycle. done_o rises together with the row-7 visit, 8 cycles after the start edge. Refresh stays off afterwards.
- R7: A start with mode 5, 6 or 7 is ignored: no strobe follows, done_o keeps its value, and refresh ticks keep their phase.
- R8: A start that arrives while a sequence or broadcast is running is ignored.
- R9: The final normal-mode step strobes no row. done_o rises T_MRD+7 cycles after the mode-register-set broadcast begins and stays high until the next accepted start.
- R10: Once refresh is on, refresh_tick_o pulses for one cycle every REF_BASE<<(code-1) cycles for rate codes 1 to 5. The first pulse comes that many cycles after done_o rises. Codes 0, 6 and 7 give no pulses.
- R11: No refresh pulse occurs before the automatic sequence has finished, while any sequence is running, or after a single-command start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| mode_sel_i | input | 3 | 0 = full sequence, 1-4 = single command, 5-7 reserved |
| row_bound_i | input | NROWS*BW | Cumulative row boundaries, 8 MB units |
| cas_l3_i | input | 1 | 1 = CAS latency 3, 0 = CAS latency 2 |
| ref_rate_i | input | 3 | Refresh rate code |
| row_cs_o | output | NROWS | One-hot chip-select strobe per row |
| cmd_o | output | 3 | Command code sent with the strobe |
| mra_o | output | 13 | Mode-register address word |
| row_base_o | output | BW | Start of the strobed row, 8 MB units |
| refresh_tick_o | output | 1 | Periodic refresh request pulse |
| done_o | output | 1 | Sequence or command finished |

## Verification
The bench aims at row skipping with empty rows, with equal boundaries and with a boundary that falls below the one before it. A design that compared a row against row 0 or against a running maximum would strobe the wrong rows or report the wrong start address. It checks the cycle of every strobe across the whole script, so an off-by-one in any wait counter or a wrong count of refreshes moves every later strobe. Both CAS latencies are used in both row halves, which exposes a swapped address pattern. Starts with reserved mode values and starts issued mid-sequence must leave the command stream, the done flag and the refresh phase untouched. Refresh must stay silent after a single-command start and for the disabled and reserved rate codes.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;
  typedef enum logic [2:0] {
    CMD_NORMAL = 3'd0,
    CMD_NOP    = 3'd1,
    CMD_PREALL = 3'd2,
    CMD_MRS    = 3'd3,
    CMD_CBR    = 3'd4
  } sdr_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_BCAST = 2'd2
  } seq_st_e;

  localparam int MRA_W = 13;
  // mode words: lower half / upper half (address lines inverted for upper pair)
  localparam logic [MRA_W-1:0] MRA_LO_CL3 = 13'h01D0;
  localparam logic [MRA_W-1:0] MRA_HI_CL3 = 13'h1E28;
  localparam logic [MRA_W-1:0] MRA_LO_CL2 = 13'h0150;
  localparam logic [MRA_W-1:0] MRA_HI_CL2 = 13'h1EA8;
endpackage

// File: rtl/sdr_row_sel.sv
module sdr_row_sel
  import sdr_seq_pkg::*;
#(
  parameter int NROWS = 8,
  parameter int BW    = 8,
  localparam int IW   = (NROWS > 1) ? $clog2(NROWS) : 1
) (
  input  logic [NROWS*BW-1:0] bounds_i,
  input  logic [IW-1:0]       row_i,
  input  logic                cas_l3_i,
  input  sdr_cmd_e            cmd_i,
  output logic                hit_o,
  output logic [BW-1:0]       prev_o,
  output logic [MRA_W-1:0]    mra_o
);
  localparam int HALF = NROWS / 2;

  logic [BW-1:0] cur_bnd;
  logic          upper;

  always_comb begin
    cur_bnd = bounds_i[int'(row_i)*BW +: BW];
    if (row_i == '0) prev_o = '0;
    else             prev_o = bounds_i[(int'(row_i) - 1)*BW +: BW];
    hit_o = (cur_bnd > prev_o);
    upper = (int'(row_i) >= HALF);
    if (cmd_i == CMD_MRS) begin
      if (upper) mra_o = cas_l3_i ? MRA_HI_CL3 : MRA_HI_CL2;
      else       mra_o = cas_l3_i ? MRA_LO_CL3 : MRA_LO_CL2;
    end else begin
      mra_o = '0;
    end
  end
endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
  parameter int REF_BASE = 1560,
  localparam int MAXP    = REF_BASE * 16,
  localparam int CW      = $clog2(MAXP + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable_i,
  input  logic [2:0] rate_i,
  output logic       tick_o
);
  logic [CW-1:0] period;
  logic [CW-1:0] cnt_q;

  always_comb begin
    case (rate_i)
      3'd1, 3'd2, 3'd3, 3'd4, 3'd5: period = CW'(REF_BASE) << (rate_i - 3'd1);
      default:                      period = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (!enable_i || period == '0) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q >= period - 1'b1) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end

  // R10
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/sdr_init_seq.sv
module sdr_init_seq
  import sdr_seq_pkg::*;
#(
  parameter int NROWS    = 8,
  parameter int BW       = 8,
  parameter int T_PWR    = 20000,
  parameter int T_RP     = 3,
  parameter int T_RC     = 7,
  parameter int T_MRD    = 2,
  parameter int N_CBR    = 8,
  parameter int REF_BASE = 1560
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [2:0]          mode_sel_i,
  input  logic [NROWS*BW-1:0] row_bound_i,
  input  logic                cas_l3_i,
  input  logic [2:0]          ref_rate_i,
  output logic [NROWS-1:0]    row_cs_o,
  output logic [2:0]          cmd_o,
  output logic [12:0]         mra_o,
  output logic [BW-1:0]       row_base_o,
  output logic                refresh_tick_o,
  output logic                done_o
);
  localparam int IW   = (NROWS > 1) ? $clog2(NROWS) : 1;
  localparam int DM1  = (T_PWR > T_RP) ? T_PWR : T_RP;
  localparam int DM2  = (T_RC > T_MRD) ? T_RC : T_MRD;
  localparam int DMAX = (DM1 > DM2) ? DM1 : DM2;
  localparam int WCW  = $clog2(DMAX + 1);
  localparam int CBW  = $clog2(N_CBR + 1);

  seq_st_e          st_q;
  sdr_cmd_e         cur_q, next_q;
  logic             auto_q, ref_en_q;
  logic [WCW-1:0]   wait_q;
  logic [IW-1:0]    row_q;
  logic [CBW-1:0]   cbr_q;

  logic             hit;
  logic [BW-1:0]    prev_bnd;
  logic [MRA_W-1:0] mra_nxt;
  logic             accept;

  assign accept = (st_q == ST_IDLE) && start_i && (mode_sel_i <= 3'd4);

  sdr_row_sel #(.NROWS(NROWS), .BW(BW)) u_row_sel (
    .bounds_i (row_bound_i),
    .row_i    (row_q),
    .cas_l3_i (cas_l3_i),
    .cmd_i    (cur_q),
    .hit_o    (hit),
    .prev_o   (prev_bnd),
    .mra_o    (mra_nxt)
  );

  sdr_refresh_timer #(.REF_BASE(REF_BASE)) u_ref_tmr (
    .clk      (clk),
    .rst      (rst),
    .enable_i (ref_en_q && (st_q == ST_IDLE) && !accept),
    .rate_i   (ref_rate_i),
    .tick_o   (refresh_tick_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      cur_q      <= CMD_NORMAL;
      next_q     <= CMD_NORMAL;
      auto_q     <= 1'b0;
      ref_en_q   <= 1'b0;
      wait_q     <= '0;
      row_q      <= '0;
      cbr_q      <= '0;
      done_o     <= 1'b0;
      row_cs_o   <= '0;
      cmd_o      <= CMD_NORMAL;
      mra_o      <= '0;
      row_base_o <= '0;
    end else begin
      row_cs_o   <= '0;
      cmd_o      <= CMD_NORMAL;
      mra_o      <= '0;
      row_base_o <= '0;
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            done_o   <= 1'b0;
            ref_en_q <= 1'b0;
            if (mode_sel_i == 3'd0) begin
              auto_q <= 1'b1;
              st_q   <= ST_WAIT;
              wait_q <= WCW'(T_PWR - 1);
              next_q <= CMD_NOP;
            end else begin
              auto_q <= 1'b0;
              st_q   <= ST_BCAST;
              cur_q  <= sdr_cmd_e'(mode_sel_i);
              row_q  <= '0;
            end
          end
        end
        ST_WAIT: begin
          if (wait_q == '0) begin
            if (next_q == CMD_NORMAL) begin
              st_q     <= ST_IDLE;
              done_o   <= 1'b1;
              ref_en_q <= 1'b1;
            end else begin
              st_q  <= ST_BCAST;
              cur_q <= next_q;
              row_q <= '0;
            end
          end else begin
            wait_q <= wait_q - 1'b1;
          end
        end
        ST_BCAST: begin
          if (hit) begin
            row_cs_o   <= NROWS'(1) << row_q;
            cmd_o      <= cur_q;
            mra_o      <= mra_nxt;
            row_base_o <= prev_bnd;
          end
          if (row_q == IW'(NROWS - 1)) begin
            if (!auto_q) begin
              st_q   <= ST_IDLE;
              done_o <= 1'b1;
            end else begin
              st_q <= ST_WAIT;
              case (cur_q)
                CMD_NOP: begin
                  wait_q <= WCW'(T_PWR - 1);
                  next_q <= CMD_PREALL;
                end
                CMD_PREALL: begin
                  wait_q <= WCW'(T_RP - 1);
                  next_q <= CMD_CBR;
                  cbr_q  <= '0;
                end
                CMD_CBR: begin
                  wait_q <= WCW'(T_RC - 1);
                  cbr_q  <= cbr_q + 1'b1;
                  next_q <= (cbr_q == CBW'(N_CBR - 1)) ? CMD_MRS : CMD_CBR;
                end
                default: begin
                  wait_q <= WCW'(T_MRD - 1);
                  next_q <= CMD_NORMAL;
                end
              endcase
            end
          end else begin
            row_q <= row_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (row_cs_o == '0 && !done_o && !refresh_tick_o && cmd_o == 3'd0));
  // R3
  onehot_cs_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_cs_o));
  // R3
  strobe_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (row_cs_o != '0) |-> (cmd_o != 3'd0 && cmd_o <= 3'd4));
  // R5
  mra_only_mrs_chk: assert property (@(posedge clk) disable iff (rst)
    (row_cs_o != '0 && cmd_o != CMD_MRS) |-> (mra_o == '0));
  // R11
  tick_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    refresh_tick_o |-> done_o);
  // R9
  done_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && $past(done_o)) |-> (row_cs_o == '0));
endmodule

// File: tb/sdr_init_seq_tb.sv
module sdr_init_seq_tb;
  localparam int NROWS = 8, BW = 8;
  localparam int T_PWR = 20, T_RP = 3, T_RC = 5, T_MRD = 2, N_CBR = 8;
  localparam int REF_BASE = 16;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, cl3 = 1'b1;
  logic [2:0] mode = 3'd0, rate = 3'd0;
  logic [7:0] bnd [NROWS];
  logic [NROWS*BW-1:0] bounds;
  logic [NROWS-1:0] row_cs;
  logic [2:0] cmd;
  logic [12:0] mra;
  logic [BW-1:0] base;
  logic tick, done;

  always #5 clk = ~clk;

  always_comb
    for (int i = 0; i < NROWS; i++) bounds[i*BW +: BW] = bnd[i];

  sdr_init_seq #(.NROWS(NROWS), .BW(BW), .T_PWR(T_PWR), .T_RP(T_RP), .T_RC(T_RC),
    .T_MRD(T_MRD), .N_CBR(N_CBR), .REF_BASE(REF_BASE)) u_dut (
    .clk(clk), .rst(rst), .start_i(start), .mode_sel_i(mode), .row_bound_i(bounds),
    .cas_l3_i(cl3), .ref_rate_i(rate), .row_cs_o(row_cs), .cmd_o(cmd), .mra_o(mra),
    .row_base_o(base), .refresh_tick_o(tick), .done_o(done));

  typedef struct {
    int          cyc;
    logic [31:0] word;
    string       tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0, n_cmp = 0, n_mis = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  function automatic logic [12:0] mra_exp(input int r, input logic [2:0] c, input logic l3);
    if (c != 3'd3) return 13'h0;
    if (r >= 4) return l3 ? 13'h1E28 : 13'h1EA8;
    return l3 ? 13'h01D0 : 13'h0150;
  endfunction

  // driver side: expected strobes of one broadcast starting at cycle t0
  task automatic push_bcast(input int t0, input logic [2:0] c, input string tag);
    for (int r = 0; r < NROWS; r++) begin
      logic [7:0] prv;
      exp_t e;
      prv = (r == 0) ? 8'd0 : bnd[r-1];
      if (bnd[r] > prv) begin
        e.cyc  = t0 + r;
        e.word = {8'(1 << r), c, mra_exp(r, c, cl3), prv};
        e.tag  = tag;
        q.push_back(e);
      end
    end
  endtask

  // monitor: compares every strobe with the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (row_cs != '0) begin
        if (q.size() == 0) chk("R3/R7/R8 unexpected strobe", {24'h0, row_cs}, 32'h0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk({e.tag, " fields"}, {row_cs, cmd, mra, base}, e.word);
          chk({e.tag, " cycle"}, cyc, e.cyc);
        end
      end
      if (tick && !done) chk("R11 tick while not done", 32'd1, 32'd0);
    end
  end

  task automatic pulse_start(input logic [2:0] m, output int s);
    @(negedge clk); start = 1'b1; mode = m;
    @(negedge clk); start = 1'b0; mode = 3'd0;
    s = cyc;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic run_auto(input int intrude, output int dcyc);
    int s, b;
    pulse_start(3'd0, s);
    chk("R9 done clears on start", {31'h0, done}, 32'd0);
    b = s + T_PWR + 1;
    push_bcast(b, 3'd1, "R2/R3/R4 NOP");       b += 8 + T_PWR;
    push_bcast(b, 3'd2, "R2/R3/R4 PRE");       b += 8 + T_RP;
    for (int k = 0; k < N_CBR; k++) begin
      push_bcast(b, 3'd4, "R2/R3/R4 CBR");     b += 8 + T_RC;
    end
    push_bcast(b, 3'd3, "R2/R5 MRS");
    dcyc = b + 7 + T_MRD;
    if (intrude > 0) begin
      int d;
      repeat (intrude) @(negedge clk);
      pulse_start(3'd2, d);  // R8: ignored while busy
    end
    wait_until(dcyc - 1);
    chk("R9 done before end", {31'h0, done}, 32'd0);
    @(negedge clk);
    chk("R9 done at end", {31'h0, done}, 32'd1);
    chk("R2/R8 all strobes seen", q.size(), 32'd0);
  endtask

  task automatic run_single(input logic [2:0] m, input string tag);
    int s;
    pulse_start(m, s);
    push_bcast(s + 1, m, tag);
    wait_until(s + 7);
    chk("R6 done low during broadcast", {31'h0, done}, 32'd0);
    @(negedge clk);
    chk("R6 done after broadcast", {31'h0, done}, 32'd1);
    @(negedge clk);
    chk("R6 strobes consumed", q.size(), 32'd0);
  endtask

  task automatic watch(input int n, input int ref0, input int per, input string tag);
    for (int i = 0; i < n; i++) begin
      logic e;
      @(negedge clk);
      e = (per > 0) && (cyc > ref0) && (((cyc - ref0) % per) == 0);
      chk(tag, {31'h0, tick}, {31'h0, e});
      chk("R9 done held", {31'h0, done}, 32'd1);
    end
  endtask

  initial begin
    int d, s;
    bnd = '{8'd2, 8'd4, 8'd6, 8'd8, 8'd10, 8'd12, 8'd14, 8'd16};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 row_cs after reset", {24'h0, row_cs}, 32'h0);
    chk("R1 done after reset", {31'h0, done}, 32'h0);
    chk("R1 tick/cmd after reset", {28'h0, tick, cmd}, 32'h0);

    // full sequence, all rows populated, CL3, fastest refresh
    rate = 3'd1; cl3 = 1'b1;
    run_auto(0, d);
    watch(50, d, REF_BASE, "R10 rate 1");
    rate = 3'd0;
    watch(40, d, 0, "R10 rate 0 silent");
    rate = 3'd6;
    watch(40, d, 0, "R10 rate 6 silent");

    // gaps, equal and falling boundaries, CL2, intruding start
    bnd = '{8'd0, 8'd4, 8'd4, 8'd8, 8'd8, 8'd8, 8'd16, 8'd12};
    cl3 = 1'b0; rate = 3'd3;
    run_auto(30, d);
    watch(140, d, REF_BASE * 4, "R10 rate 3");
    pulse_start(3'd5, s);
    chk("R7 done kept mode 5", {31'h0, done}, 32'd1);
    pulse_start(3'd6, s);
    pulse_start(3'd7, s);
    watch(60, d, REF_BASE * 4, "R7 reserved start keeps refresh phase");

    // single commands
    bnd = '{8'd1, 8'd1, 8'd3, 8'd2, 8'd5, 8'd9, 8'd9, 8'd20};
    cl3 = 1'b1; rate = 3'd1;
    run_single(3'd2, "R6/R3/R4 single PRE");
    watch(40, 0, 0, "R11 no refresh after single command");
    run_single(3'd3, "R6/R5 single MRS CL3");
    cl3 = 1'b0;
    run_single(3'd3, "R6/R5 single MRS CL2");
    run_single(3'd4, "R6 single CBR");
    run_single(3'd1, "R6 single NOP");
    watch(20, 0, 0, "R11 still silent");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_mis++;
    $display("FAIL watchdog expired (R2 sequence hung): actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule